// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This engine walks a circular list of 16-byte transmit descriptors held in word-addressed memory. It gathers the buffer segments named by those descriptors into frames and sends each frame out as a byte stream. Software prepares descriptors, gives each one to the engine with an ownership bit, and then pulses a poll strobe. The engine fetches descriptors until it finds one it does not own. After sending a segment it hands the descriptor back by clearing the ownership bit in memory.

A descriptor is four little-endian 32-bit words. Word 0 holds the segment length in bits 13:0, an end-of-ring mark in bit 15, a last-segment mark in bit 28, a first-segment mark in bit 29 and the ownership bit in bit 31. Word 1 carries per-frame flags: bit 31 asks for a packet-sent event and bit 30 asks for a per-descriptor event. Word 2 is never read. Word 3 is the buffer address.

Three one-cycle event pulses report what happened: packet sent, descriptor done and ring run-out. Software collects them into its interrupt causes. Memory is reached through a request/grant port. The outgoing byte stream follows valid/ready rules: once `tx_valid` is high it stays high, and `tx_data` and `tx_last` stay unchanged, until a cycle in which `tx_ready` is also high. The engine never needs `tx_ready` high in order to raise `tx_valid`. Dropping either enable in the middle of a scan does not stop that scan: it runs until the ring runs out.

Top module: `txring_engine`

## Requirements
- R1: A poll strobe starts a scan only when both `dma_en` and `mac_en` are high. A strobe that arrives while the engine is idle with either enable low is dropped: no memory access, no output, no event.
- R2: A scan fetches word 0 at the current pointer. If bit 31 of that word is clear, the engine pulses `evt_nobuf` for one cycle, goes idle and leaves the pointer on that descriptor. `tx_valid` is low in that cycle.
- R3: A segment takes its length from word-0 bits 13:0 and its buffer from word 3, with address bits 1:0 ignored. Its bytes go out in ascending address order, with the byte in bits 7:0 of each word first.
- R4: Word 1 becomes the frame flags only when word-0 bit 29 (first) is set; later segments keep those flags and their own word 1 has no effect. Word-0 bit 28 (last) ends the frame, and `tx_last` marks the final byte of that frame.
- R5: `evt_sent` pulses once for each descriptor with bit 28 set, when flag bit 31 is set.
- R6: `evt_seg` pulses once for each processed descriptor whose current flags have bit 30 set.
- R7: Each processed descriptor is written back to the address its word 0 was read from. The value written is the word 0 that was read, with bit 31 cleared and all other bits unchanged.
- R8: After a write-back, the pointer moves to the ring base if word-0 bit 15 is set; otherwise it moves to the current address plus 16.
- R9: A frame holds at most 1522 bytes, or 9220 when `jumbo_en` is high. A segment that would go past that limit is cut to the room left, and a segment with no room left sends no bytes.
- R10: A `base_wr` pulse loads both the ring base and the current pointer from `base_in`, with bits 3:0 forced to zero, at the next clock edge. This takes priority over the pointer step.
- R11: Poll strobes that arrive during a scan are remembered as a single pending request. That request starts exactly one more scan once the current scan ends.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values into the next cycle.
- R13: `mem_req` holds its address, write enable and write data unchanged until `mem_gnt` is seen. Addresses are word aligned. Read data is taken on `mem_rdata` one cycle after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_en | input | 1 | Transmit DMA enable |
| mac_en | input | 1 | Transmit MAC enable |
| jumbo_en | input | 1 | Selects the larger frame limit |
| poll | input | 1 | Poll-demand strobe |
| base_wr | input | 1 | Loads ring base and pointer |
| base_in | input | ADDR_W | New ring base byte address |
| cur_desc | output | ADDR_W | Current descriptor byte address |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory grant |
| mem_rdata | input | 32 | Read data, one cycle after grant |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a frame |
| evt_sent | output | 1 | Packet-sent event pulse |
| evt_seg | output | 1 | Descriptor-done event pulse |
| evt_nobuf | output | 1 | Ring run-out event pulse |

## Verification
The assertions check on every cycle the behaviour that can be seen locally:
- the stream and memory handshakes hold their values while stalled;
- request addresses are word aligned;
- every write-back clears the ownership bit;
- a base load reaches the pointer one cycle later;
- no frame grows past its limit;
- a run-out never comes with stream output.

Other behaviour spans a whole scan and only the bench scenarios can show it. This covers byte order and the position of the last marker over a sweep of segment lengths, flags taken from the first segment only, the ring wrap, and truncation at both frame limits. It also covers a poll dropped while disabled and the coalescing of several polls into one extra scan.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RQ0, ST_DT0, ST_RQ1, ST_DT1, ST_RQ3, ST_DT3,
    ST_RQB, ST_DTB, ST_EMIT, ST_FLUSH, ST_WB, ST_NEXT
  } txr_state_e;

  localparam int OWN_BIT    = 31;
  localparam int FIRST_BIT  = 29;
  localparam int LAST_BIT   = 28;
  localparam int EOR_BIT    = 15;
  localparam int FL_PKT_BIT = 31;
  localparam int FL_SEG_BIT = 30;
endpackage

// File: rtl/txr_poll_ctl.sv
module txr_poll_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic poll,
  input  logic idle,
  input  logic enable,
  output logic start
);
  logic pend;

  // a request seen while idle is either consumed now or dropped
  assign start = idle && (poll || pend) && enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else if (idle) pend <= 1'b0;
    else if (poll) pend <= 1'b1;
  end
endmodule

// File: rtl/txr_byte_stage.sv
module txr_byte_stage (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  input  logic       flush,
  output logic       flush_done,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last
);
  logic       hold_v;
  logic [7:0] hold_d;

  // one byte is held back until it is known whether it ends the frame
  assign out_valid  = hold_v && (in_valid || flush);
  assign out_last   = flush && !in_valid;
  assign out_data   = hold_d;
  assign in_ready   = !hold_v || out_ready;
  assign flush_done = !hold_v || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_d <= '0;
    end else if (in_valid && in_ready) begin
      hold_v <= 1'b1;
      hold_d <= in_data;
    end else if (flush && flush_done) begin
      hold_v <= 1'b0;
    end
  end
endmodule

// File: rtl/txring_engine.sv
module txring_engine
  import txr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 14,
  parameter int MAX_STD   = 1522,
  parameter int MAX_JUMBO = 9220
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_en,
  input  logic              mac_en,
  input  logic              jumbo_en,
  input  logic              poll,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_in,
  output logic [ADDR_W-1:0] cur_desc,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              evt_sent,
  output logic              evt_seg,
  output logic              evt_nobuf
);
  localparam logic [ADDR_W-1:0] STRIDE    = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] FLAG_OFS  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] BUF_OFS   = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] ALIGN16   = ~ADDR_W'(15);

  txr_state_e        st;
  logic [ADDR_W-1:0] cur, base, ptr;
  logic [31:0]       w0, wbuf;
  logic              fl_pkt, fl_seg;
  logic [LEN_W-1:0]  rem, fcnt, maxf, room, seg_len, eff;
  logic [1:0]        bidx;
  logic              start, acc, fdone, byte_v, flush;
  logic [7:0]        byte_d;

  assign cur_desc = cur;
  assign maxf     = jumbo_en ? LEN_W'(MAX_JUMBO) : LEN_W'(MAX_STD);
  assign room     = maxf - fcnt;
  assign seg_len  = w0[LEN_W-1:0];
  assign eff      = (seg_len > room) ? room : seg_len;
  assign byte_v   = (st == ST_EMIT);
  assign byte_d   = wbuf[{bidx, 3'b000} +: 8];
  assign flush    = (st == ST_FLUSH);

  txr_poll_ctl u_poll (
    .clk(clk), .rst_n(rst_n), .poll(poll), .idle(st == ST_IDLE),
    .enable(dma_en && mac_en), .start(start)
  );

  txr_byte_stage u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(byte_v), .in_data(byte_d),
    .in_ready(acc), .flush(flush), .flush_done(fdone),
    .out_valid(tx_valid), .out_ready(tx_ready), .out_data(tx_data),
    .out_last(tx_last)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st)
      ST_RQ0: begin mem_req = 1'b1; mem_addr = cur; end
      ST_RQ1: begin mem_req = 1'b1; mem_addr = cur + FLAG_OFS; end
      ST_RQ3: begin mem_req = 1'b1; mem_addr = cur + BUF_OFS; end
      ST_RQB: begin mem_req = (rem != '0); mem_addr = ptr; end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur;
        mem_wdata = w0 & ~(32'h1 << OWN_BIT);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur       <= '0;
      base      <= '0;
      ptr       <= '0;
      w0        <= '0;
      wbuf      <= '0;
      fl_pkt    <= 1'b0;
      fl_seg    <= 1'b0;
      rem       <= '0;
      fcnt      <= '0;
      bidx      <= '0;
      evt_sent  <= 1'b0;
      evt_seg   <= 1'b0;
      evt_nobuf <= 1'b0;
    end else begin
      evt_sent  <= 1'b0;
      evt_seg   <= 1'b0;
      evt_nobuf <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) st <= ST_RQ0;
        ST_RQ0:  if (mem_gnt) st <= ST_DT0;
        ST_DT0: begin
          w0 <= mem_rdata;
          if (!mem_rdata[OWN_BIT]) begin
            evt_nobuf <= 1'b1;
            st        <= ST_IDLE;
          end else begin
            st <= ST_RQ1;
          end
        end
        ST_RQ1: if (mem_gnt) st <= ST_DT1;
        ST_DT1: begin
          if (w0[FIRST_BIT]) begin
            fl_pkt <= mem_rdata[FL_PKT_BIT];
            fl_seg <= mem_rdata[FL_SEG_BIT];
          end
          st <= ST_RQ3;
        end
        ST_RQ3: if (mem_gnt) st <= ST_DT3;
        ST_DT3: begin
          ptr <= mem_rdata[ADDR_W-1:0] & ~ADDR_W'(3);
          rem <= eff;
          st  <= ST_RQB;
        end
        ST_RQB: begin
          if (rem == '0) st <= w0[LAST_BIT] ? ST_FLUSH : ST_WB;
          else if (mem_gnt) st <= ST_DTB;
        end
        ST_DTB: begin
          wbuf <= mem_rdata;
          bidx <= '0;
          st   <= ST_EMIT;
        end
        ST_EMIT: begin
          if (acc) begin
            rem  <= rem - LEN_W'(1);
            fcnt <= fcnt + LEN_W'(1);
            bidx <= bidx + 2'd1;
            if (rem == LEN_W'(1) || bidx == 2'd3) begin
              ptr <= ptr + WORD_STEP;
              st  <= ST_RQB;
            end
          end
        end
        ST_FLUSH: begin
          if (fdone) begin
            fcnt <= '0;
            st   <= ST_WB;
          end
        end
        ST_WB: begin
          if (mem_gnt) begin
            evt_seg  <= fl_seg;
            evt_sent <= w0[LAST_BIT] && fl_pkt;
            st       <= ST_NEXT;
          end
        end
        ST_NEXT: st <= ST_RQ0;
        default: st <= ST_IDLE;
      endcase

      if (base_wr) begin
        base <= base_in & ALIGN16;
        cur  <= base_in & ALIGN16;
      end else if (st == ST_NEXT) begin
        cur <= w0[EOR_BIT] ? base : cur + STRIDE;
      end
    end
  end
endmodule

// File: rtl/txring_engine_chk.sv
module txring_engine_chk #(
  parameter int ADDR_W    = 16,
  parameter int MAX_STD   = 1522,
  parameter int MAX_JUMBO = 9220
) (
  input logic              clk,
  input logic              rst_n,
  input logic              jumbo_en,
  input logic              base_wr,
  input logic [ADDR_W-1:0] base_in,
  input logic [ADDR_W-1:0] cur_desc,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_gnt,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              tx_last,
  input logic [7:0]        tx_data,
  input logic              evt_nobuf
);
  logic [15:0] bcnt;
  logic [31:0] limit;

  assign limit = jumbo_en ? 32'(MAX_JUMBO) : 32'(MAX_STD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= '0;
    else if (tx_valid && tx_ready) bcnt <= tx_last ? 16'd0 : bcnt + 16'd1;
  end

  // R12
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  // R13
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                           && $stable(mem_wdata));

  // R13
  mem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  // R7
  wb_own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31]);

  // R10
  base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> cur_desc == ($past(base_in) & ~ADDR_W'(15)));

  // R9
  frame_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |-> 32'(bcnt) < limit);

  // R2
  nobuf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_nobuf |-> !tx_valid);
endmodule

bind txring_engine txring_engine_chk #(
  .ADDR_W(ADDR_W), .MAX_STD(MAX_STD), .MAX_JUMBO(MAX_JUMBO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .jumbo_en(jumbo_en), .base_wr(base_wr),
  .base_in(base_in), .cur_desc(cur_desc), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last),
  .tx_data(tx_data), .evt_nobuf(evt_nobuf)
);

// File: tb/sim_txring_engine.sv
`timescale 1ns/1ps
module sim_txring_engine;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dma_en = 1'b0, mac_en = 1'b0, jumbo_en = 1'b0, poll = 1'b0;
  logic          base_wr = 1'b0;
  logic [AW-1:0] base_in = '0;
  logic [AW-1:0] cur_desc, mem_addr;
  logic          mem_req, mem_we, mem_gnt, tx_valid, tx_ready, tx_last;
  logic [31:0]   mem_wdata, mem_rdata;
  logic [7:0]    tx_data;
  logic          evt_sent, evt_seg, evt_nobuf;

  always #4 clk = ~clk;

  txring_engine u0 (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .mac_en(mac_en),
    .jumbo_en(jumbo_en), .poll(poll), .base_wr(base_wr), .base_in(base_in),
    .cur_desc(cur_desc), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .evt_sent(evt_sent),
    .evt_seg(evt_seg), .evt_nobuf(evt_nobuf)
  );

  // ---------------- memory model ----------------
  logic [31:0] mem [0:4095];
  logic        fill = 1'b0;
  logic        bd_we = 1'b0;
  logic [AW-1:0] bd_addr = '0;
  logic [31:0] bd_data = '0;
  logic [31:0] rdata_r = '0;
  logic [15:0] lfsr = 16'hACE1;
  logic        gnt_r = 1'b1, rdy_r = 1'b1;
  int          stall_mode = 0;

  assign mem_gnt   = gnt_r;
  assign tx_ready  = rdy_r;
  assign mem_rdata = rdata_r;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7) + (a >> 5) + 1);
  endfunction

  always @(negedge clk) begin
    lfsr  <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    gnt_r <= (stall_mode == 0) || lfsr[0] || lfsr[5];
    rdy_r <= (stall_mode == 0) || lfsr[3];
  end

  always @(posedge clk) begin
    if (fill) begin
      for (int k = 0; k < 4096; k++)
        mem[k] <= {pat(4*k+3), pat(4*k+2), pat(4*k+1), pat(4*k)};
    end else if (bd_we) begin
      mem[bd_addr[13:2]] <= bd_data;
    end else if (mem_req && mem_gnt) begin
      if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
      else rdata_r <= mem[mem_addr[13:2]];
    end
  end

  // ---------------- stream capture and event counting ----------------
  logic [8:0] exp_q[$];
  int got_idx = 0, mism = 0, extra = 0;
  int n_sent = 0, n_seg = 0, n_nobuf = 0;

  initial forever begin
    @(posedge clk);
    if (evt_sent)  n_sent++;
    if (evt_seg)   n_seg++;
    if (evt_nobuf) n_nobuf++;
    if (tx_valid === 1'b1 && tx_ready) begin
      if (got_idx < exp_q.size()) begin
        if ({tx_last, tx_data} != exp_q[got_idx]) begin
          mism++;
          if (mism < 5)
            $display("byte %0d mismatch: got %h want %h", got_idx,
                     {tx_last, tx_data}, exp_q[got_idx]);
        end
      end else begin
        extra++;
      end
      got_idx++;
    end
  end

  // ---------------- checking ----------------
  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input longint act,
                     input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    finish_run();
  end

  // ---------------- stimulus helpers ----------------
  task automatic bd_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bd_we = 1'b1; bd_addr = AW'(a); bd_data = d;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  function automatic logic [31:0] mk0(input int len, input bit first,
                                      input bit last, input bit eor, input bit own);
    return (32'(len) & 32'h3fff) | (32'(eor) << 15) | (32'(last) << 28)
         | (32'(first) << 29) | (32'(own) << 31);
  endfunction

  task automatic put_desc(input int a, input logic [31:0] w0,
                          input logic [31:0] w1, input int bufa);
    bd_write(a, w0);
    bd_write(a + 4, w1);
    bd_write(a + 8, 32'h0);
    bd_write(a + 12, 32'(bufa));
  endtask

  task automatic exp_bytes(input int bufa, input int n, input bit end_frame);
    for (int k = 0; k < n; k++) exp_q.push_back({1'b0, pat((bufa & ~3) + k)});
    if (end_frame) exp_q[exp_q.size() - 1][8] = 1'b1;
  endtask

  task automatic set_base(input int a);
    @(negedge clk);
    base_wr = 1'b1; base_in = AW'(a);
    @(negedge clk);
    base_wr = 1'b0;
  endtask

  task automatic pulse_poll();
    @(negedge clk);
    poll = 1'b1;
    @(negedge clk);
    poll = 1'b0;
  endtask

  task automatic wait_nobuf(input int target);
    int t = 0;
    while (n_nobuf < target && t < 40000) begin
      @(negedge clk);
      t++;
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic check_stream(input string req);
    chk(mism == 0 && extra == 0, req, mism + extra, 0);
    chk(got_idx == exp_q.size(), req, got_idx, exp_q.size());
  endtask

  // ---------------- scenarios ----------------
  task automatic sweep(input int mode);
    int base = 32'h100;
    int s0, g0, nb0;
    stall_mode = mode;
    set_base(base);
    chk(cur_desc == AW'(base), "R10 base load", cur_desc, base);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] w1;
      w1 = ((i % 2) ? 32'h8000_0000 : 32'h0) | ((i % 3 == 0) ? 32'h4000_0000 : 32'h0);
      put_desc(base + 16*i, mk0(i + 1, 1'b1, 1'b1, i == 7, 1'b1), w1, 32'h1000 + 64*i);
      exp_bytes(32'h1000 + 64*i, i + 1, 1'b1);
    end
    s0 = n_sent; g0 = n_seg; nb0 = n_nobuf;
    pulse_poll();
    wait_nobuf(nb0 + 1);
    check_stream("R3 R4 sweep bytes and last marker");
    chk(n_sent - s0 == 4, "R5 sent events", n_sent - s0, 4);
    chk(n_seg - g0 == 3, "R6 seg events", n_seg - g0, 3);
    chk(n_nobuf - nb0 == 1, "R2 run-out event", n_nobuf - nb0, 1);
    for (int i = 0; i < 8; i++)
      chk(mem[(base + 16*i) >> 2] == mk0(i + 1, 1'b1, 1'b1, i == 7, 1'b0),
          "R7 write-back", mem[(base + 16*i) >> 2], mk0(i + 1, 1'b1, 1'b1, i == 7, 1'b0));
    chk(cur_desc == AW'(base), "R8 wrap to base", cur_desc, base);
  endtask

  initial begin
    int s0, g0, nb0, g_before;
    repeat (3) @(negedge clk);
    fill = 1'b1;
    @(negedge clk);
    fill = 1'b0;
    chk(tx_valid == 1'b0, "R12 reset stream idle", tx_valid, 0);
    chk(cur_desc == '0, "R10 reset pointer", cur_desc, 0);
    chk(mem_req == 1'b0, "R13 reset no request", mem_req, 0);
    rst_n = 1'b1;
    dma_en = 1'b1; mac_en = 1'b1;

    // length sweep, free-running then with stalls on both ports
    sweep(0);
    sweep(1);

    // R4: multi-segment frame, flags from first only; R3: low address bits ignored
    stall_mode = 1;
    set_base(32'h200);
    put_desc(32'h200, mk0(5, 1, 0, 0, 1), 32'h8000_0000, 32'h1402);
    put_desc(32'h210, mk0(6, 0, 0, 0, 1), 32'h4000_0000, 32'h1500);
    put_desc(32'h220, mk0(3, 0, 1, 1, 1), 32'h0, 32'h1600);
    exp_bytes(32'h1400, 5, 0);
    exp_bytes(32'h1500, 6, 0);
    exp_bytes(32'h1600, 3, 1);
    s0 = n_sent; g0 = n_seg; nb0 = n_nobuf;
    pulse_poll();
    wait_nobuf(nb0 + 1);
    check_stream("R3 R4 multi-segment frame");
    chk(n_sent - s0 == 1, "R5 one sent event per frame", n_sent - s0, 1);
    chk(n_seg - g0 == 0, "R4 later word 1 ignored", n_seg - g0, 0);
    chk(cur_desc == AW'(32'h200), "R8 wrap after three", cur_desc, 32'h200);

    // R9: truncation at the standard limit
    stall_mode = 0;
    set_base(32'h300);
    put_desc(32'h300, mk0(1500, 1, 0, 0, 1), 32'h8000_0000, 32'h1000);
    put_desc(32'h310, mk0(100, 0, 1, 0, 1), 32'h0, 32'h2000);
    put_desc(32'h320, mk0(1600, 1, 1, 0, 1), 32'h8000_0000, 32'h1000);
    put_desc(32'h330, mk0(1522, 1, 0, 0, 1), 32'h8000_0000, 32'h1000);
    put_desc(32'h340, mk0(10, 0, 1, 1, 1), 32'h0, 32'h2000);
    exp_bytes(32'h1000, 1500, 0);
    exp_bytes(32'h2000, 22, 1);
    exp_bytes(32'h1000, 1522, 1);
    exp_bytes(32'h1000, 1522, 1);
    s0 = n_sent; nb0 = n_nobuf;
    pulse_poll();
    wait_nobuf(nb0 + 1);
    check_stream("R9 truncation to 1522");
    chk(n_sent - s0 == 3, "R5 truncated frames sent", n_sent - s0, 3);
    chk(mem[32'h310 >> 2] == mk0(100, 0, 1, 0, 0), "R7 length kept on write-back",
        mem[32'h310 >> 2], mk0(100, 0, 1, 0, 0));

    // R9: jumbo limit
    jumbo_en = 1'b1;
    set_base(32'h380);
    put_desc(32'h380, mk0(9300, 1, 1, 1, 1), 32'h8000_0000, 32'h1000);
    exp_bytes(32'h1000, 9220, 1);
    nb0 = n_nobuf;
    pulse_poll();
    wait_nobuf(nb0 + 1);
    check_stream("R9 truncation to 9220");
    jumbo_en = 1'b0;

    // R1: poll dropped while disabled; R10: low base bits forced to zero
    set_base(32'h3C7);
    chk(cur_desc == AW'(32'h3C0), "R10 base alignment", cur_desc, 32'h3C0);
    put_desc(32'h3C0, mk0(4, 1, 1, 1, 1), 32'h0, 32'h1800);
    mac_en = 1'b0;
    g_before = got_idx; nb0 = n_nobuf;
    pulse_poll();
    repeat (40) @(negedge clk);
    chk(got_idx == g_before, "R1 no output while disabled", got_idx, g_before);
    chk(n_nobuf == nb0, "R1 no scan while disabled", n_nobuf, nb0);
    chk(mem[32'h3C0 >> 2][31] == 1'b1, "R1 descriptor untouched", mem[32'h3C0 >> 2][31], 1);
    mac_en = 1'b1;
    repeat (5) @(negedge clk);
    chk(n_nobuf == nb0, "R1 dropped poll not replayed", n_nobuf, nb0);
    exp_bytes(32'h1800, 4, 1);
    pulse_poll();
    wait_nobuf(nb0 + 1);
    check_stream("R1 scan once enabled");

    // R11: polls during a scan coalesce into one extra scan
    stall_mode = 1;
    set_base(32'h3A0);
    put_desc(32'h3A0, mk0(40, 1, 1, 1, 1), 32'h0, 32'h1900);
    exp_bytes(32'h1900, 40, 1);
    nb0 = n_nobuf;
    pulse_poll();
    repeat (3) @(negedge clk);
    pulse_poll();
    pulse_poll();
    wait_nobuf(nb0 + 2);
    repeat (40) @(negedge clk);
    chk(n_nobuf - nb0 == 2, "R11 one extra scan", n_nobuf - nb0, 2);
    check_stream("R11 frame during latched polls");

    finish_run();
  end
endmodule